// File: doc/BRIEF.md
# Pushbutton Input Port with Release Capture

This block sits on a simple word-addressed register bus and watches four pushbuttons. The raw key lines are asynchronous and active low. Each line passes through a two-flop synchronizer. Software can then read three registers: the live pressed state of every key, a set of sticky event flags, and a per-key interrupt enable.

An event flag is raised when the synchronized key shows a complete press followed by a release. The flag stays raised until software writes a one to that bit position. The normal pattern is to read the flags and write the same value straight back. A level interrupt line is high while any raised flag has its enable bit set. Clearing the flags therefore also drops the request. Debouncing and interrupt routing are left to neighbouring blocks.

Top module: `pb_capture_port`

## Requirements
- R1: After reset the level register reads 0, the enable register reads 0, the event register reads 0 and irq is low.
- R2: A read at byte offset 0x0 returns the pressed state of each key. Key k is reported in bit k, and a key counts as pressed while its input is low. A change at the input shows on the read data after two rising clock edges.
- R3: A read at byte offset 0xC returns the event flags. Bit k goes to 1 on the third rising edge after key k's input returns high, provided the synchronized key was seen pressed before. A press alone never sets a flag.
- R4: Once set, an event flag stays 1 until a write to offset 0xC carries a 1 in that bit position.
- R5: A write to offset 0xC clears exactly the flags whose write-data bits are 1 and leaves the others unchanged. Writing 0xF clears every flag.
- R6: A write to byte offset 0x8 stores write-data bits 3:0 as the enable bits, bit k for key k, with 1 meaning enabled. A read at 0x8 returns them.
- R7: irq is high exactly when some key has both its event flag and its enable bit at 1. Clearing those flags, or disabling those keys, drops irq.
- R8: If a flag's set condition and a clear write for that bit fall on the same clock edge, the flag ends up set.
- R9: Read-data bits 31:4 are always 0. Reads at other offsets such as 0x4 return 0. Writes to offset 0x0 change no register.
- R10: Keys act independently. Several keys pressed and released together each set their own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keys_n | input | 4 | Raw key lines, low while pressed |
| bus_addr | input | 4 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Suppose a synchronizer stage or the held-state register goes wrong. The event flags then appear a cycle early or late, or they appear on a press instead of a release. The bench compares the event register every cycle against a timing model that counts the three register stages, so such an error shows within one clock. A faulty clear or enable bit shows on the next edge through the read data and through irq. Same-edge set and clear is driven on purpose, so a clear that wrongly wins drops a flag that the model keeps.

// File: rtl/pb_capture_port.sv
`timescale 1ns/1ps
module pb_capture_port #(
  parameter int NUM_KEYS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] keys_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq
);
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_ENABLE = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_EVENT  = ADDR_W'(12);

  logic [NUM_KEYS-1:0] meta_q, sync_q, held_q, event_q, mask_q;
  logic [NUM_KEYS-1:0] pressed;

  wire clr_hit  = bus_we && (bus_addr == OFS_EVENT);
  wire mask_hit = bus_we && (bus_addr == OFS_ENABLE);

  assign pressed = ~sync_q;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    wire released_now = held_q[k] & ~pressed[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[k] <= 1'b1;
        sync_q[k] <= 1'b1;
        held_q[k] <= 1'b0;
      end else begin
        meta_q[k] <= keys_n[k];
        sync_q[k] <= meta_q[k];
        held_q[k] <= pressed[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        event_q[k] <= 1'b0;
      else if (released_now)             event_q[k] <= 1'b1;
      else if (clr_hit && bus_wdata[k])  event_q[k] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q[k] <= 1'b0;
      else if (mask_hit) mask_q[k] <= bus_wdata[k];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_LEVEL:  bus_rdata[NUM_KEYS-1:0] = pressed;
      OFS_ENABLE: bus_rdata[NUM_KEYS-1:0] = mask_q;
      OFS_EVENT:  bus_rdata[NUM_KEYS-1:0] = event_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = |(event_q & mask_q);
endmodule

// File: rtl/pb_capture_port_chk.sv
`timescale 1ns/1ps
module pb_capture_port_chk #(
  parameter int NUM_KEYS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                irq,
  input logic [NUM_KEYS-1:0] held_q,
  input logic [NUM_KEYS-1:0] event_q,
  input logic [NUM_KEYS-1:0] mask_q
);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_EV = ADDR_W'(12);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  assert_capture_needs_press_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((event_q & ~$past(event_q) & ~$past(held_q)) == '0));

  assert_capture_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(bus_we && bus_addr == A_EV)) |-> ((event_q & $past(event_q)) == $past(event_q)));

  assert_clear_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bus_we && bus_addr == A_EV)) |->
      ((event_q & $past(bus_wdata[NUM_KEYS-1:0] & ~held_q)) == '0));

  assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bus_we && bus_addr == A_EN)) |-> (mask_q == $past(bus_wdata[NUM_KEYS-1:0])));

  assert_irq_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(irq)) |-> $past(bus_we));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_KEYS] == '0);
endmodule

bind pb_capture_port pb_capture_port_chk #(
  .NUM_KEYS(NUM_KEYS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .held_q(held_q), .event_q(event_q), .mask_q(mask_q)
);

// File: tb/test_pb_capture_port.sv
`timescale 1ns/1ps
module test_pb_capture_port;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  keys_n = 4'hF;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pb_capture_port i_pb_capture_port (
    .clk(clk), .rst_n(rst_n), .keys_n(keys_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Reference model: history of sampled pressed states, oldest first.
  logic [3:0] hist[$];
  logic [3:0] m_event, m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{4'h0, 4'h0, 4'h0};
      m_event = 4'h0;
      m_mask  = 4'h0;
    end else begin
      logic [3:0] setv, clrv;
      setv = hist[0] & ~hist[1];
      clrv = (bus_we && bus_addr == 4'hC) ? bus_wdata[3:0] : 4'h0;
      m_event = (m_event & ~clrv) | setv;
      if (bus_we && bus_addr == 4'h8) m_mask = bus_wdata[3:0];
      hist.push_back(~keys_n);
      void'(hist.pop_front());
    end
  end

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'h0: return {28'h0, hist[1]};
      4'h8: return {28'h0, m_mask};
      4'hC: return {28'h0, m_event};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    #(CLK_P/5);
    if (rst_n && !done) begin
      case (bus_addr)
        4'h0: chk("R2 level cycle", bus_rdata, model_read(bus_addr));
        4'h8: chk("R6 enable cycle", bus_rdata, model_read(bus_addr));
        4'hC: chk("R3 event cycle", bus_rdata, model_read(bus_addr));
        default: chk("R9 unmapped cycle", bus_rdata, model_read(bus_addr));
      endcase
      chk("R7 irq cycle", {31'h0, irq}, {31'h0, |(m_event & m_mask)});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    rd_chk("R1 level after reset", 4'h0, 32'h0);
    rd_chk("R1 enable after reset", 4'h8, 32'h0);
    rd_chk("R1 event after reset", 4'hC, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    @(negedge clk) keys_n = 4'b1101;
    idle(2);
    rd_chk("R2 key1 pressed", 4'h0, 32'h2);
    idle(6);
    rd_chk("R3 press alone sets nothing", 4'hC, 32'h0);

    @(negedge clk) keys_n = 4'hF;
    idle(3);
    rd_chk("R3 release sets flag", 4'hC, 32'h2);
    chk("R7 masked off", {31'h0, irq}, 32'h0);

    wr(4'h8, 32'h2);
    rd_chk("R6 enable readback", 4'h8, 32'h2);
    chk("R7 irq raised", {31'h0, irq}, 32'h1);
    idle(10);
    rd_chk("R4 flag sticky", 4'hC, 32'h2);

    @(negedge clk) keys_n = 4'b0110;
    idle(4);
    rd_chk("R10 two keys level", 4'h0, 32'h9);
    @(negedge clk) keys_n = 4'hF;
    idle(4);
    rd_chk("R10 two keys captured", 4'hC, 32'hB);

    wr(4'hC, 32'h2);
    rd_chk("R5 clear exact bit", 4'hC, 32'h9);
    chk("R7 clear drops irq", {31'h0, irq}, 32'h0);
    wr(4'hC, 32'hF);
    rd_chk("R5 clear all", 4'hC, 32'h0);

    wr(4'h0, 32'hFFFF_FFFF);
    rd_chk("R9 data write ignored", 4'h0, 32'h0);
    rd_chk("R9 unmapped offset", 4'h4, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd_chk("R9 upper bits zero", 4'h8, 32'hF);

    @(negedge clk) keys_n = 4'b1011;
    idle(4);
    @(negedge clk) keys_n = 4'hF;
    @(negedge clk);
    wr(4'hC, 32'hF);
    rd_chk("R8 set beats clear", 4'hC, 32'h4);
    chk("R8 irq stays", {31'h0, irq}, 32'h1);
    wr(4'hC, 32'h4);
    rd_chk("R5 final clear", 4'hC, 32'h0);

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule